// File: doc/BRIEF.md
# Bus Activity Monitor Channel

This block watches one or more streams of bus activity pulses. Each pulse that arrives while a channel is running adds a programmable weight to that channel's period accumulator. A shared timer splits time into sampling periods. The timer is a clock prescaler followed by a programmable tick counter. When a period closes, each running channel does four things. It folds the accumulated total into an exponential running average. It compares the raw total against a high and a low threshold. It counts how many periods in a row broke each threshold. It compares the new average against its own pair of thresholds.

A software agent reaches the block through a flat register port. It programs the thresholds, the weight, a starting value for the average and a control word. It reads back the average and a sticky event word that it clears by writing ones. A single level interrupt stays high while any channel holds a sticky event. A global summary word shows which channels are pending.

Top module: `act_mon_top`

## Requirements
- R1: After reset every register reads zero, the interrupt is low, and no channel counts or samples.
- R2: The global period register at offset 0x4 holds the period length minus one, in prescaler ticks, so a period lasts (P+1)*PRESC clock cycles. The timer is held at zero while no channel is running, and it starts counting on the cycle after a channel becomes enabled.
- R3: On each cycle with its event input high, a running channel adds the weight register (offset 0x18) to its period total. The total saturates at all ones. An event on the closing cycle of a period is counted in the next period.
- R4: At each period close the average becomes avg + ((total - avg) >>> (K+1)), where K is control bits 12:10 and the shift is arithmetic. Writing offset 0xC loads the average directly, and offset 0x20 reads it back.
- R5: A period breaks high when its total is greater than the threshold at 0x4, and breaks low when its total is less than the threshold at 0x8. A period that does not break a direction resets that direction's run counter.
- R6: Control bits 28:26 (high) and 25:23 (low) hold the required run length minus one. When a run reaches that length, event bit 31 (high) or bit 30 (low) is set and the run counter starts again from zero, so a lasting breach sets the bit once every N periods. Control bit 30 enables the high direction and bit 29 enables the low direction. Any write to the control register clears both run counters.
- R7: After the average is updated, event bit 29 is set if the average is greater than the threshold at 0x10 and control bit 21 is set. Event bit 28 is set if the average is less than the threshold at 0x14 and control bit 20 is set.
- R8: Writing ones to the event word (offset 0x24) clears those bits. If a write clears a bit on the same cycle that the bit is being set, the set wins.
- R9: A channel runs only while control bit 31 (enable) and bit 18 (periodic sampling) are both set. A stopped channel ignores events and period closes, and keeps both its average and its total.
- R10: The interrupt is high while any channel's event word is nonzero. Global offset 0x0 reports channel i at bit 26-i.
- R11: Channel i's registers sit at CH_BASE + i*0x40. Accesses to one channel do not touch another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| evt_i | input | NUM_CH | Per-channel activity pulse, sampled every clock |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions rely on two assumptions about the inputs. Software rewrites the control word whenever it changes the required run lengths. The event word changes only because of period closes and write-one clears. The bench keeps within both. Every configuration change is a control write made while the channel is stopped. The only status clears are ones the bench schedules inside a period, either on the first cycle or on the closing cycle. The bench also starts a channel only while every other channel is stopped. This keeps the period boundaries at fixed cycle offsets from the enabling write.

// File: rtl/act_mon_pkg.sv
`timescale 1ns/1ps
package act_mon_pkg;

    localparam int AM_DW    = 32;
    localparam int AM_OFF_W = 6;
    localparam int AM_K_W   = 3;
    localparam int AM_RUN_W = 3;

    typedef enum logic [AM_OFF_W-1:0] {
        OFF_CTRL = 6'h00,
        OFF_HI   = 6'h04,
        OFF_LO   = 6'h08,
        OFF_SEED = 6'h0C,
        OFF_AHI  = 6'h10,
        OFF_ALO  = 6'h14,
        OFF_WGT  = 6'h18,
        OFF_AVG  = 6'h20,
        OFF_EVT  = 6'h24
    } chan_off_e;

    localparam logic [AM_DW-1:0] CTRL_MASK = 32'hFFB4_1C00;

    typedef struct packed {
        logic                en;
        logic                hi_en;
        logic                lo_en;
        logic [AM_RUN_W-1:0] hi_num;
        logic [AM_RUN_W-1:0] lo_num;
        logic                avg_hi_en;
        logic                avg_lo_en;
        logic                sample;
        logic [AM_K_W-1:0]   k;
    } chan_cfg_t;

    // event word layout, kept in the top nibble of offset 0x24
    typedef struct packed {
        logic run_hi;
        logic run_lo;
        logic avg_hi;
        logic avg_lo;
    } chan_evt_t;

    function automatic chan_cfg_t cfg_unpack(input logic [AM_DW-1:0] r);
        chan_cfg_t c;
        c.en        = r[31];
        c.hi_en     = r[30];
        c.lo_en     = r[29];
        c.hi_num    = r[28:26];
        c.lo_num    = r[25:23];
        c.avg_hi_en = r[21];
        c.avg_lo_en = r[20];
        c.sample    = r[18];
        c.k         = r[12:10];
        return c;
    endfunction

    function automatic logic [AM_DW-1:0] sat_add(input logic [AM_DW-1:0] a,
                                                input logic [AM_DW-1:0] b);
        logic [AM_DW:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[AM_DW] ? {AM_DW{1'b1}} : s[AM_DW-1:0];
    endfunction

    function automatic logic [AM_DW-1:0] avg_next(input logic [AM_DW-1:0] avg,
                                                 input logic [AM_DW-1:0] tot,
                                                 input logic [AM_K_W-1:0] k);
        logic signed [AM_DW:0] diff;
        logic signed [AM_DW:0] step;
        logic [AM_K_W:0]       sh;
        diff = $signed({1'b0, tot}) - $signed({1'b0, avg});
        sh   = {1'b0, k} + 1'b1;
        step = diff >>> sh;
        return avg + step[AM_DW-1:0];
    endfunction

endpackage

// File: rtl/act_mon_timer.sv
`timescale 1ns/1ps
module act_mon_timer #(
    parameter int PRESC = 4,
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [PER_W-1:0] period_i,
    output logic             close_o
);
    localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;

    logic             tick;
    logic [PER_W-1:0] tick_q;

    generate
        if (PRESC == 1) begin : g_nodiv
            assign tick = run_i;
        end else begin : g_div
            logic [PW-1:0] div_q;
            always_ff @(posedge clk) begin
                if (rst || !run_i)
                    div_q <= '0;
                else if (div_q == PW'(PRESC-1))
                    div_q <= '0;
                else
                    div_q <= div_q + 1'b1;
            end
            assign tick = run_i && (div_q == PW'(PRESC-1));
        end
    endgenerate

    assign close_o = tick && (tick_q >= period_i);

    always_ff @(posedge clk) begin
        if (rst || !run_i)
            tick_q <= '0;
        else if (close_o)
            tick_q <= '0;
        else if (tick)
            tick_q <= tick_q + 1'b1;
    end
endmodule

// File: rtl/act_mon_chan.sv
`timescale 1ns/1ps
module act_mon_chan
    import act_mon_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_i,
    input  logic [AM_OFF_W-1:0] off_i,
    input  logic [AM_DW-1:0]    wdata_i,
    input  logic                evt_i,
    input  logic                close_i,
    output logic [AM_DW-1:0]    rdata_o,
    output logic                irq_o,
    output logic                active_o,
    output logic                seed_wr_o,
    output logic [AM_DW-1:0]    avg_o,
    output logic [AM_DW-1:0]    tot_o,
    output logic [AM_RUN_W-1:0] run_hi_o,
    output logic [AM_RUN_W-1:0] hi_num_o
);
    logic [AM_DW-1:0]    ctrl_q, hi_q, lo_q, ahi_q, alo_q, wgt_q, avg_q, tot_q;
    logic [AM_RUN_W-1:0] run_hi_q, run_lo_q, run_hi_d, run_lo_d;
    chan_evt_t           evt_q, evt_set, evt_clr;
    chan_cfg_t           cfg;
    logic                closing, brk_hi, brk_lo;
    logic [AM_DW-1:0]    avg_d;

    assign cfg      = cfg_unpack(ctrl_q);
    assign active_o = cfg.en && cfg.sample;
    assign closing  = close_i && active_o;
    assign brk_hi   = tot_q > hi_q;
    assign brk_lo   = tot_q < lo_q;
    assign avg_d    = avg_next(avg_q, tot_q, cfg.k);

    always_comb begin
        evt_set  = '0;
        run_hi_d = '0;
        run_lo_d = '0;
        if (cfg.hi_en && brk_hi) begin
            if (run_hi_q == cfg.hi_num) evt_set.run_hi = closing;
            else                        run_hi_d = run_hi_q + 1'b1;
        end
        if (cfg.lo_en && brk_lo) begin
            if (run_lo_q == cfg.lo_num) evt_set.run_lo = closing;
            else                        run_lo_d = run_lo_q + 1'b1;
        end
        evt_set.avg_hi = closing && cfg.avg_hi_en && (avg_d > ahi_q);
        evt_set.avg_lo = closing && cfg.avg_lo_en && (avg_d < alo_q);
    end

    assign evt_clr   = (wr_i && off_i == OFF_EVT) ? chan_evt_t'(wdata_i[31:28]) : '0;
    assign seed_wr_o = wr_i && off_i == OFF_SEED;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0; hi_q <= '0; lo_q <= '0; ahi_q <= '0; alo_q <= '0;
            wgt_q <= '0; avg_q <= '0; tot_q <= '0;
            run_hi_q <= '0; run_lo_q <= '0; evt_q <= '0;
        end else begin
            if (closing) begin
                avg_q    <= avg_d;
                tot_q    <= evt_i ? wgt_q : '0;
                run_hi_q <= run_hi_d;
                run_lo_q <= run_lo_d;
            end else if (active_o && evt_i) begin
                tot_q <= sat_add(tot_q, wgt_q);
            end
            evt_q <= (evt_q & ~evt_clr) | evt_set;
            if (wr_i) begin
                case (off_i)
                    OFF_CTRL: begin
                        ctrl_q   <= wdata_i & CTRL_MASK;
                        run_hi_q <= '0;
                        run_lo_q <= '0;
                    end
                    OFF_HI:   hi_q  <= wdata_i;
                    OFF_LO:   lo_q  <= wdata_i;
                    OFF_AHI:  ahi_q <= wdata_i;
                    OFF_ALO:  alo_q <= wdata_i;
                    OFF_WGT:  wgt_q <= wdata_i;
                    OFF_SEED: avg_q <= wdata_i;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (off_i)
            OFF_CTRL: rdata_o = ctrl_q;
            OFF_HI:   rdata_o = hi_q;
            OFF_LO:   rdata_o = lo_q;
            OFF_AHI:  rdata_o = ahi_q;
            OFF_ALO:  rdata_o = alo_q;
            OFF_WGT:  rdata_o = wgt_q;
            OFF_AVG:  rdata_o = avg_q;
            OFF_EVT:  rdata_o = {evt_q, 28'h0};
            default:  rdata_o = '0;
        endcase
    end

    assign irq_o    = |evt_q;
    assign avg_o    = avg_q;
    assign tot_o    = tot_q;
    assign run_hi_o = run_hi_q;
    assign hi_num_o = cfg.hi_num;
endmodule

// File: rtl/act_mon_top.sv
`timescale 1ns/1ps
module act_mon_top
    import act_mon_pkg::*;
#(
    parameter int NUM_CH  = 2,
    parameter int AW      = 10,
    parameter int CH_BASE = 256,
    parameter int PRESC   = 4,
    parameter int PER_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [AW-1:0]     reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [NUM_CH-1:0] evt_i,
    output logic              irq_o
);
    localparam int BLK_W   = AW - AM_OFF_W;
    localparam int BLK0    = CH_BASE >> AM_OFF_W;
    localparam int GST_TOP = 26;
    localparam logic [AM_OFF_W-1:0] OFF_GPER = 6'h04;

    logic [BLK_W-1:0]    blk;
    logic [AM_OFF_W-1:0] off;
    logic                glob_sel;
    logic [PER_W-1:0]    period_q;
    logic                period_end_w, any_active, stat_wr_w;

    logic [NUM_CH-1:0]                ch_sel, ch_irq, ch_active_w, ch_seed_wr_w;
    logic [NUM_CH-1:0][AM_DW-1:0]     ch_rdata, ch_avg_w, ch_tot_w;
    logic [NUM_CH-1:0][AM_RUN_W-1:0]  ch_run_hi_w, ch_hi_num_w;
    logic [31:0]                      gstat, ch_rd_or;

    assign blk      = reg_addr[AW-1:AM_OFF_W];
    assign off      = reg_addr[AM_OFF_W-1:0];
    assign glob_sel = (blk == '0);

    always_ff @(posedge clk) begin
        if (rst)
            period_q <= '0;
        else if (reg_wr && glob_sel && off == OFF_GPER)
            period_q <= reg_wdata[PER_W-1:0];
    end

    assign any_active = |ch_active_w;

    act_mon_timer #(.PRESC(PRESC), .PER_W(PER_W)) u_timer (
        .clk(clk), .rst(rst), .run_i(any_active),
        .period_i(period_q), .close_o(period_end_w)
    );

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            assign ch_sel[i] = (blk == BLK_W'(BLK0 + i));
            act_mon_chan u_chan (
                .clk(clk), .rst(rst),
                .wr_i(reg_wr && ch_sel[i]), .off_i(off), .wdata_i(reg_wdata),
                .evt_i(evt_i[i]), .close_i(period_end_w),
                .rdata_o(ch_rdata[i]), .irq_o(ch_irq[i]),
                .active_o(ch_active_w[i]), .seed_wr_o(ch_seed_wr_w[i]),
                .avg_o(ch_avg_w[i]), .tot_o(ch_tot_w[i]),
                .run_hi_o(ch_run_hi_w[i]), .hi_num_o(ch_hi_num_w[i])
            );
        end
    endgenerate

    assign stat_wr_w = reg_wr && (|ch_sel) && (off == OFF_EVT);

    always_comb begin
        gstat    = '0;
        ch_rd_or = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            gstat[GST_TOP-i] = ch_irq[i];
            if (ch_sel[i]) ch_rd_or = ch_rd_or | ch_rdata[i];
        end
    end

    always_comb begin
        if (glob_sel) begin
            case (off)
                6'h00:    reg_rdata = gstat;
                OFF_GPER: reg_rdata = 32'(period_q);
                default:  reg_rdata = '0;
            endcase
        end else begin
            reg_rdata = ch_rd_or;
        end
    end

    assign irq_o = |ch_irq;
endmodule

// File: rtl/act_mon_chk.sv
`timescale 1ns/1ps
module act_mon_chk #(
    parameter int NUM_CH = 2
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   period_end,
    input logic                   irq_o,
    input logic                   stat_wr,
    input logic [NUM_CH-1:0]      ch_active,
    input logic [NUM_CH-1:0]      ch_seed_wr,
    input logic [NUM_CH-1:0][31:0] ch_avg,
    input logic [NUM_CH-1:0][31:0] ch_tot,
    input logic [NUM_CH-1:0][2:0]  ch_run_hi,
    input logic [NUM_CH-1:0][2:0]  ch_hi_num
);
    // R10: the interrupt can only rise after a period close
    p_irq_rise_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(period_end));

    // R8: the interrupt can only fall after a status clear write
    p_irq_fall_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_o) |-> $past(stat_wr));

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            // R9: a stopped channel keeps its average
            p_avg_hold_r9: assert property (@(posedge clk) disable iff (rst)
                (!ch_active[i] && !ch_seed_wr[i]) |=> $stable(ch_avg[i]));

            // R3: the total never falls except at a close
            p_tot_mono_r3: assert property (@(posedge clk) disable iff (rst)
                !(period_end && ch_active[i]) |=> (ch_tot[i] >= $past(ch_tot[i])));

            // R6: the run counter never passes the programmed length
            p_run_bound_r6: assert property (@(posedge clk) disable iff (rst)
                ch_run_hi[i] <= ch_hi_num[i]);
        end
    endgenerate
endmodule

bind act_mon_top act_mon_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst(rst), .period_end(period_end_w), .irq_o(irq_o),
    .stat_wr(stat_wr_w), .ch_active(ch_active_w), .ch_seed_wr(ch_seed_wr_w),
    .ch_avg(ch_avg_w), .ch_tot(ch_tot_w), .ch_run_hi(ch_run_hi_w),
    .ch_hi_num(ch_hi_num_w)
);

// File: tb/sim_act_mon_top.sv
`timescale 1ns/1ps
module sim_act_mon_top;
    localparam int NCH = 2;
    localparam int PR  = 2;
    localparam int PER = 3;
    localparam int L   = (PER + 1) * PR;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NCH-1:0] evt = '0;
    logic        irq;

    always #2.5 clk = ~clk;

    act_mon_top #(.NUM_CH(NCH), .AW(10), .CH_BASE(256), .PRESC(PR), .PER_W(16)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt), .irq_o(irq)
    );

    typedef struct {
        string       tag;
        logic [31:0] avg;
        logic [31:0] st;
        logic        irq;
        logic [31:0] gst;
    } item_t;

    item_t exp_q[$];
    item_t act_q[$];
    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference state for the channel under test
    int     cur;
    longint m_avg, m_w, m_hi, m_lo, m_ahi, m_alo;
    int     m_k, m_hn, m_ln, m_runh, m_runl;
    bit     m_he, m_le, m_ahe, m_ale;
    logic [3:0] m_st;

    function automatic logic [9:0] base(input int ch);
        return 10'(256 + ch * 64);
    endfunction

    function automatic logic [31:0] mk_ctrl(input bit en, input bit smp, input int k,
        input bit he, input int hn, input bit le, input int ln, input bit ahe, input bit ale);
        logic [31:0] v = '0;
        v[31] = en; v[30] = he; v[29] = le; v[28:26] = 3'(hn); v[25:23] = 3'(ln);
        v[21] = ahe; v[20] = ale; v[18] = smp; v[12:10] = 3'(k);
        return v;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.2;
        d = reg_rdata;
    endtask

    task automatic apply_ctrl(input bit en, input bit smp);
        wr(base(cur), mk_ctrl(en, smp, m_k, m_he, m_hn, m_le, m_ln, m_ahe, m_ale));
        m_runh = 0; m_runl = 0;
    endtask

    task automatic setup(input int ch, input longint w, input longint hi, input longint lo,
        input longint ahi, input longint alo, input longint seed, input int k,
        input bit he, input int hn, input bit le, input int ln, input bit ahe, input bit ale);
        cur = ch; m_w = w; m_hi = hi; m_lo = lo; m_ahi = ahi; m_alo = alo; m_avg = seed;
        m_k = k; m_he = he; m_hn = hn; m_le = le; m_ln = ln; m_ahe = ahe; m_ale = ale;
        wr(base(ch) + 10'h18, 32'(w));
        wr(base(ch) + 10'h04, 32'(hi));
        wr(base(ch) + 10'h08, 32'(lo));
        wr(base(ch) + 10'h10, 32'(ahi));
        wr(base(ch) + 10'h14, 32'(alo));
        wr(base(ch) + 10'h0C, 32'(seed));
        apply_ctrl(1'b1, 1'b1);
    endtask

    task automatic model_close(input int k);
        longint c, d;
        c = k * m_w;
        if (c > 64'hFFFF_FFFF) c = 64'hFFFF_FFFF;
        d = c - m_avg;
        m_avg = m_avg + (d >>> (m_k + 1));
        if (m_he && c > m_hi) begin
            if (m_runh == m_hn) begin m_st[3] = 1'b1; m_runh = 0; end
            else m_runh++;
        end else m_runh = 0;
        if (m_le && c < m_lo) begin
            if (m_runl == m_ln) begin m_st[2] = 1'b1; m_runl = 0; end
            else m_runl++;
        end else m_runl = 0;
        if (m_ahe && m_avg > m_ahi) m_st[1] = 1'b1;
        if (m_ale && m_avg < m_alo) m_st[0] = 1'b1;
    endtask

    // driver: one whole period, k events on its first cycles, optional clear at cycle clr_at
    task automatic run_period(input int k, input int clr_at, input string tag);
        item_t e, a;
        for (int i = 0; i < L; i++) begin
            evt = (i < k) ? NCH'(1 << cur) : '0;
            if (i == clr_at) begin
                reg_wr = 1'b1; reg_addr = base(cur) + 10'h24; reg_wdata = 32'hF000_0000;
                m_st = '0;
            end
            @(posedge clk); @(negedge clk);
            reg_wr = 1'b0;
        end
        evt = '0;
        model_close(k);
        e.tag = tag; e.avg = 32'(m_avg); e.st = {m_st, 28'h0};
        e.irq = |m_st; e.gst = (|m_st) ? (32'h1 << (26 - cur)) : 32'h0;
        exp_q.push_back(e);
        a.tag = tag;
        rd(base(cur) + 10'h20, a.avg);
        rd(base(cur) + 10'h24, a.st);
        rd(10'h000, a.gst);
        a.irq = irq;
        act_q.push_back(a);
    endtask

    // monitor: compares what the design produced with what the driver expected
    initial begin
        item_t a, e;
        forever begin
            wait (act_q.size() > 0);
            a = act_q.pop_front();
            e = exp_q.pop_front();
            check({e.tag, " avg R4"}, a.avg, e.avg);
            check({e.tag, " status"}, a.st, e.st);
            check({e.tag, " irq R10"}, 32'(a.irq), 32'(e.irq));
            check({e.tag, " global R10"}, a.gst, e.gst);
        end
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        m_st = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(base(0), v);           check("R1 ctrl", v, 32'h0);
        rd(base(0) + 10'h20, v);  check("R1 avg", v, 32'h0);
        rd(10'h000, v);           check("R1 global", v, 32'h0);
        check("R1 irq", 32'(irq), 32'h0);

        // R2: period register
        wr(10'h004, 32'(PER));
        rd(10'h004, v);           check("R2 period", v, 32'(PER));

        setup(0, 'h10, 'h40, 'h20, 'h60, 'h08, 'h30, 0, 1, 1, 1, 0, 1, 1);
        rd(base(0) + 10'h20, v);  check("R4 seed", v, 32'h30);

        run_period(5, -1, "R6 first");
        run_period(5, -1, "R6 second");
        run_period(3,  0, "R8 clear");
        run_period(5, -1, "R5 run");
        run_period(3, -1, "R5 break");
        run_period(5, -1, "R5 restart");
        run_period(1, -1, "R6 low");
        run_period(7,  0, "R7 climb");
        for (int j = 0; j < 5; j++) run_period(7, -1, "R7 hold");
        run_period(7,  0, "R6 lasting");
        run_period(7, -1, "R6 lasting");
        run_period(7, -1, "R6 lasting");
        run_period(1, L - 1, "R8 set wins");

        // R9: stopped channel ignores events
        wr(base(0) + 10'h24, 32'hF000_0000); m_st = '0;
        apply_ctrl(1'b0, 1'b1);
        for (int i = 0; i < L; i++) begin
            evt = 2'b01; @(posedge clk); @(negedge clk);
        end
        evt = '0;
        rd(base(0) + 10'h20, v);  check("R9 avg kept", v, 32'(m_avg));
        check("R9 irq", 32'(irq), 32'h0);
        apply_ctrl(1'b1, 1'b0);
        for (int i = 0; i < L; i++) begin
            evt = 2'b01; @(posedge clk); @(negedge clk);
        end
        evt = '0;
        rd(base(0) + 10'h20, v);  check("R9 no sampling", v, 32'(m_avg));
        wr(base(0), 32'h0);
        apply_ctrl(1'b1, 1'b1);
        run_period(0, -1, "R9 empty total");

        // R3: saturation
        apply_ctrl(1'b0, 1'b1);
        wr(base(0) + 10'h24, 32'hF000_0000); m_st = '0;
        setup(0, 'h8000_0000, 'hFFFF_FFFE, 0, 'hFFFF_FFFF, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        run_period(3, -1, "R3 saturate");
        apply_ctrl(1'b0, 1'b1);
        wr(base(0) + 10'h24, 32'hF000_0000); m_st = '0;

        // R11: second channel
        setup(1, 1, 2, 0, 'hFFFF_FFFF, 0, 'h40, 2, 1, 2, 0, 0, 0, 0);
        run_period(3, -1, "R11 ch1");
        run_period(3, -1, "R11 ch1");
        run_period(3, -1, "R11 ch1 fire");
        rd(base(0) + 10'h18, v);  check("R11 ch0 untouched", v, 32'h8000_0000);
        rd(base(1) + 10'h00, v);
        check("R11 ch1 ctrl", v, mk_ctrl(1, 1, 2, 1, 2, 0, 0, 0, 0));

        wait (act_q.size() == 0);
        #1;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule